// File: doc/BRIEF.md
# Multi-Channel Display Data Fetcher

This block holds a set of independent fetch channels behind a small register window on a CPU bus. Each channel keeps an 11-bit pointer that counts down, two 8-bit compare values (called top and bottom here), and an 8-bit window flag. When the CPU reads a channel's display function, the block returns a byte from a 2 KB internal display memory. The byte's address is the channel pointer mirrored from the top of the memory. The pointer then steps down by one. A program can therefore stream a sprite or playfield column with one read per line and no address arithmetic of its own.

The window flag turns on when the low pointer byte reaches the top value. It turns off when the low byte reaches the bottom value. One read function ANDs the fetched byte with this flag, so the CPU gets a vertical window clip without spending any cycles on it.

Two side units sit outside the block: a random generator and a tone unit. The block passes their values through to the CPU, and it sends a reseed pulse to the random generator. The tone unit also supplies a hold bit for each of the last three channels. A separate load port fills the display memory.

Top module: `disp_fetch_bank`

## Requirements
- R1: After reset, every channel's pointer, top value, bottom value and flag are zero. `bus_rdata` is 0 and `rng_reseed` is 0.
- R2: A read acts only when `bus_rd` is high and the address is in 0x000–0x03F. A write acts only when `bus_wr` is high and the address is in 0x040–0x07F. Address bits [2:0] pick the channel and bits [5:3] pick the function. An access at any other address changes no state and leaves `bus_rdata` unchanged.
- R3: Write function 0 loads the top value and clears the channel's flag to 0x00. Write function 1 loads the bottom value.
- R4: Write function 2 loads the low 8 pointer bits. Write function 3 loads pointer bits [10:8] from data bits [2:0] and leaves the low 8 bits unchanged. On channels 5–7, when the channel's hold bit is set, write function 2 loads the top value instead of the written data.
- R5: Write function 6 raises `rng_reseed` for exactly the one cycle after the write edge. Write functions 4, 5 and 7 have no effect.
- R6: Read function 1 returns the display memory byte at address 0x7FF minus the channel's pointer, using the pointer value from before the read. `bus_rdata` takes the read result on the read edge and holds it until the next read.
- R7: On every read, the flag is updated before the data is formed. It becomes 0xFF if the low pointer byte equals top. Otherwise it becomes 0x00 if the low byte equals bottom. Otherwise it keeps its value. Read function 7 returns the updated flag.
- R8: Read function 2 returns the display byte ANDed with the updated flag.
- R9: Read function 0 returns `rng_value` on channels 0–3 and `tone_level` on channels 4–7. Read functions 3–6 return 0.
- R10: After every read, the addressed channel's pointer decrements modulo 2048, so 0 wraps to 0x7FF. Channels 5, 6 and 7 do not decrement while `tone_hold` bit 0, 1 or 2, respectively, is set.
- R11: When `ld_en` is high, the load port writes `ld_data` to display memory address `ld_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rdata | output | 8 | Registered read result |
| ld_en | input | 1 | Display memory load enable |
| ld_addr | input | 11 | Display memory load address |
| ld_data | input | 8 | Display memory load data |
| rng_value | input | 8 | Current value of the external random generator |
| tone_level | input | 8 | Current level from the external tone unit |
| tone_hold | input | 3 | Hold bits for channels 5, 6, 7 |
| rng_reseed | output | 1 | One-cycle reseed pulse to the random generator |

## Verification
A read strobe held high across one rising edge produces its result on `bus_rdata` right after that edge. The pointer step and flag change made on that same edge show up only in the next read. A write takes effect on its edge, and `rng_reseed` is high only in the cycle that follows it. The bench drives every access at a falling edge and samples at the next falling edge, one edge later. For the reseed pulse it samples once more a cycle after that to confirm the pulse has dropped. A reference model in the bench tracks the pointers, compare values and flags from the requirements. It predicts each read's result, including the wrap at zero and any held channel, before the edge.

// File: rtl/dfb_pkg.sv
package dfb_pkg;

    // Read function codes (address bits [5:3] inside the read half)
    typedef enum logic [2:0] {
        RF_SIDE = 3'd0,
        RF_DISP = 3'd1,
        RF_MASK = 3'd2,
        RF_FLAG = 3'd7
    } rd_fn_e;

    // Write function codes (address bits [5:3] inside the write half)
    typedef enum logic [2:0] {
        WF_TOP    = 3'd0,
        WF_BOT    = 3'd1,
        WF_LO     = 3'd2,
        WF_HI     = 3'd3,
        WF_RESEED = 3'd6
    } wr_fn_e;

endpackage

// File: rtl/dfb_display_mem.sv
module dfb_display_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) mem_q[ld_addr] <= ld_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dfb_channel.sv
module dfb_channel #(
    parameter int CNT_W  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              wr_top,
    input  logic              wr_bot,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hold,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] flag_eval
);
    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] top;
        logic [DATA_W-1:0] bot;
        logic [DATA_W-1:0] flag;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        // flag as seen by a read in this cycle: top match wins over bottom
        if (st_q.cnt[DATA_W-1:0] == st_q.top)
            flag_eval = '1;
        else if (st_q.cnt[DATA_W-1:0] == st_q.bot)
            flag_eval = '0;
        else
            flag_eval = st_q.flag;

        st_d = st_q;
        if (rd_go) begin
            st_d.flag = flag_eval;
            if (!hold) st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_top) begin
            st_d.top  = wdata;
            st_d.flag = '0;
        end
        if (wr_bot) st_d.bot = wdata;
        if (wr_lo)  st_d.cnt[DATA_W-1:0] = hold ? st_q.top : wdata;
        if (wr_hi)  st_d.cnt[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2: the top decode never strobes two actions into one channel at once
    p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_go, wr_top, wr_bot, wr_lo, wr_hi}));

    // R2: with no strobe the channel state does not move
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go || wr_top || wr_bot || wr_lo || wr_hi) |=> $stable(st_q));

    // R10: a free-running read steps the pointer down by one, wrapping
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !hold) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    // R10: a held channel keeps its pointer across a read
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hold) |=> $stable(st_q.cnt));

    // R7: a read at the top value leaves the flag all ones
    p_flag_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && st_q.cnt[DATA_W-1:0] == st_q.top) |=> st_q.flag == '1);

    // R4: the high-part write keeps the low pointer byte
    p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> st_q.cnt[DATA_W-1:0] == $past(st_q.cnt[DATA_W-1:0]));

    // R3: loading top clears the flag
    p_top_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_top |=> st_q.flag == '0);

endmodule

// File: rtl/disp_fetch_bank.sv
module disp_fetch_bank
    import dfb_pkg::*;
#(
    parameter int N_CHAN = 8,
    parameter int HOLD_N = 3,
    parameter int CNT_W  = 11,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    input  logic                bus_wr,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ld_en,
    input  logic [CNT_W-1:0]    ld_addr,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic [DATA_W-1:0]   rng_value,
    input  logic [DATA_W-1:0]   tone_level,
    input  logic [HOLD_N-1:0]   tone_hold,
    output logic                rng_reseed
);
    localparam int CH_W      = $clog2(N_CHAN);
    localparam int WIN_BIT   = CH_W + 3;
    localparam int HOLD_BASE = N_CHAN - HOLD_N;
    localparam int RAND_N    = N_CHAN / 2;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              reseed;
    } top_t;

    top_t st_d, st_q;

    logic [CH_W-1:0]   sel_ch;
    logic [2:0]        sel_fn;
    logic              in_page;
    logic              rd_hit;
    logic              wr_hit;
    logic [CNT_W-1:0]  cnt_arr  [N_CHAN];
    logic [DATA_W-1:0] flag_arr [N_CHAN];
    logic [CNT_W-1:0]  mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    assign sel_ch  = bus_addr[CH_W-1:0];
    assign sel_fn  = bus_addr[CH_W+2:CH_W];
    assign in_page = (bus_addr[ADDR_W-1:WIN_BIT+1] == '0);
    assign rd_hit  = bus_rd && in_page && !bus_addr[WIN_BIT];
    assign wr_hit  = bus_wr && in_page &&  bus_addr[WIN_BIT];

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        logic hit, hold_i;
        assign hit = (sel_ch == CH_W'(i));
        if (i >= HOLD_BASE) begin : g_hold
            assign hold_i = tone_hold[i-HOLD_BASE];
        end else begin : g_free
            assign hold_i = 1'b0;
        end
        dfb_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_go     (rd_hit && hit),
            .wr_top    (wr_hit && hit && sel_fn == WF_TOP),
            .wr_bot    (wr_hit && hit && sel_fn == WF_BOT),
            .wr_lo     (wr_hit && hit && sel_fn == WF_LO),
            .wr_hi     (wr_hit && hit && sel_fn == WF_HI),
            .wdata     (bus_wdata),
            .hold      (hold_i),
            .cnt       (cnt_arr[i]),
            .flag_eval (flag_arr[i])
        );
    end

    // mirrored addressing: top of memory minus pointer
    assign mem_raddr = ~cnt_arr[sel_ch];

    dfb_display_mem #(.AW(CNT_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reseed = wr_hit && (sel_fn == WF_RESEED);
        if (rd_hit) begin
            unique case (sel_fn)
                RF_SIDE: st_d.rdata = (int'(sel_ch) < RAND_N) ? rng_value : tone_level;
                RF_DISP: st_d.rdata = mem_rdata;
                RF_MASK: st_d.rdata = mem_rdata & flag_arr[sel_ch];
                RF_FLAG: st_d.rdata = flag_arr[sel_ch];
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign rng_reseed = st_q.reseed;

    // R5: a reseed pulse only ever follows a write strobe
    p_reseed_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rng_reseed |-> $past(bus_wr));

    // R6: read data holds while no read is accepted
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(bus_rdata));

    // R9: the unused read functions return zero
    p_unused_fn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && sel_fn inside {3'd3, 3'd4, 3'd5, 3'd6}) |=> bus_rdata == '0);

    // R2: an access outside the window never yields a reseed
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_page) |=> !rng_reseed);

endmodule

// File: tb/tb_disp_fetch_bank.sv
module tb_disp_fetch_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_rdata;
    logic        ld_en;
    logic [10:0] ld_addr;
    logic [7:0]  ld_data;
    logic [7:0]  rng_value, tone_level;
    logic [2:0]  tone_hold;
    logic        rng_reseed;

    always #4 clk = ~clk;

    disp_fetch_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rng_value(rng_value), .tone_level(tone_level), .tone_hold(tone_hold),
        .rng_reseed(rng_reseed)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference model built from the requirements
    logic [7:0]  m_mem  [2048];
    logic [10:0] m_cnt  [8];
    logic [7:0]  m_top  [8];
    logic [7:0]  m_bot  [8];
    logic [7:0]  m_flag [8];
    logic [7:0]  m_rdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic bus_read(input logic [11:0] a, input string req);
        int         ch;
        logic [2:0] fn;
        logic [7:0] fe, d;
        ch = int'(a[2:0]);
        fn = a[5:3];
        if (a[11:6] == 6'd0) begin
            fe = m_flag[ch];
            if (m_cnt[ch][7:0] == m_top[ch])      fe = 8'hFF;
            else if (m_cnt[ch][7:0] == m_bot[ch]) fe = 8'h00;
            d = m_mem[11'h7FF - m_cnt[ch]];
            case (fn)
                3'd0:    m_rdata = (ch < 4) ? rng_value : tone_level;
                3'd1:    m_rdata = d;
                3'd2:    m_rdata = d & fe;
                3'd7:    m_rdata = fe;
                default: m_rdata = 8'h00;
            endcase
            m_flag[ch] = fe;
            if (!(ch >= 5 && tone_hold[ch-5])) m_cnt[ch] = m_cnt[ch] - 11'd1;
        end
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, 32'(bus_rdata), 32'(m_rdata));
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] v, input string req);
        int         ch;
        logic [2:0] fn;
        logic       exp_rs;
        ch     = int'(a[2:0]);
        fn     = a[5:3];
        exp_rs = 1'b0;
        if (a[11:6] == 6'd1) begin
            case (fn)
                3'd0: begin m_top[ch] = v; m_flag[ch] = 8'h00; end
                3'd1: m_bot[ch] = v;
                3'd2: m_cnt[ch][7:0] = (ch >= 5 && tone_hold[ch-5]) ? m_top[ch] : v;
                3'd3: m_cnt[ch][10:8] = v[2:0];
                3'd6: exp_rs = 1'b1;
                default: ;
            endcase
        end
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check(req, 32'(rng_reseed), 32'(exp_rs));
    endtask

    task automatic set_ptr(input int ch, input logic [10:0] p);
        bus_write(12'h058 + 12'(ch), {5'd0, p[10:8]}, "R4");
        bus_write(12'h050 + 12'(ch), p[7:0], "R4");
    endtask

    task automatic t_reset();
        check("R1 rdata", 32'(bus_rdata), 32'h0);
        check("R1 reseed", 32'(rng_reseed), 32'h0);
        bus_read(12'h00B, "R1 pointer zero, display at 0x7FF");
        bus_read(12'h03B, "R1 flag after read of zeroed channel");
    endtask

    task automatic t_display();
        set_ptr(1, 11'h123);
        bus_read(12'h009, "R6 display byte");
        bus_read(12'h009, "R6 next byte after step");
        bus_read(12'h009, "R6 third byte");
        bus_write(12'h059, 8'hFD, "R4 high write");
        bus_read(12'h009, "R4 high bits masked, low kept");
    endtask

    task automatic t_wrap();
        set_ptr(3, 11'h001);
        bus_read(12'h00B, "R10 pointer 1");
        bus_read(12'h00B, "R10 pointer 0");
        bus_read(12'h00B, "R10 wrapped to 0x7FF");
    endtask

    task automatic t_window();
        bus_write(12'h042, 8'h05, "R3 top");
        bus_write(12'h04A, 8'h02, "R3 bottom");
        set_ptr(2, 11'h207);
        for (int k = 0; k < 8; k++) begin
            bus_read(12'h012, "R8 masked byte");
            bus_read(12'h03A, "R7 flag read");
        end
    endtask

    task automatic t_priority();
        bus_write(12'h044, 8'h30, "R3 top");
        bus_write(12'h04C, 8'h30, "R3 bottom equal to top");
        set_ptr(4, 11'h030);
        bus_read(12'h03C, "R7 top wins over bottom");
        set_ptr(4, 11'h030);
        bus_write(12'h044, 8'h31, "R3 top moves, flag cleared");
        bus_read(12'h03C, "R7 bottom match clears");
        bus_read(12'h03C, "R7 no match keeps flag");
        bus_write(12'h044, 8'h2E, "R3 top");
        bus_read(12'h03C, "R7 top match sets");
        bus_write(12'h044, 8'h00, "R3 top write clears flag");
        bus_read(12'h03C, "R3 flag cleared by top write");
    endtask

    task automatic t_side();
        rng_value  = 8'hA5;
        tone_level = 8'h3C;
        bus_read(12'h000, "R9 random on channel 0");
        bus_read(12'h003, "R9 random on channel 3");
        bus_read(12'h004, "R9 tone on channel 4");
        bus_read(12'h007, "R9 tone on channel 7");
        bus_read(12'h019, "R9 function 3 reads zero");
        bus_read(12'h021, "R9 function 4 reads zero");
        bus_read(12'h029, "R9 function 5 reads zero");
        bus_read(12'h031, "R9 function 6 reads zero");
        bus_read(12'h009, "R10 steps from other functions seen");
    endtask

    task automatic t_hold();
        set_ptr(5, 11'h444);
        set_ptr(6, 11'h555);
        bus_write(12'h046, 8'h40, "R3 top ch6");
        tone_hold = 3'b010;
        bus_read(12'h00E, "R10 held channel 6");
        bus_read(12'h00E, "R10 held channel 6 again");
        bus_read(12'h00D, "R10 channel 5 free");
        bus_read(12'h00D, "R10 channel 5 stepped");
        bus_write(12'h056, 8'h99, "R4 held low write");
        bus_read(12'h00E, "R4 held low write took top value");
        tone_hold = 3'b000;
        bus_read(12'h00E, "R10 released channel 6");
        bus_read(12'h00E, "R10 channel 6 stepping");
    endtask

    task automatic t_reseed();
        bus_write(12'h070, 8'h00, "R5 reseed pulse");
        @(negedge clk);
        check("R5 reseed one cycle", 32'(rng_reseed), 32'h0);
        bus_write(12'h061, 8'h12, "R5 function 4 ignored");
        bus_write(12'h069, 8'h34, "R5 function 5 ignored");
        bus_write(12'h079, 8'h56, "R5 function 7 ignored");
        bus_read(12'h009, "R5 ignored writes left pointer");
    endtask

    task automatic t_decode();
        bus_write(12'h0C1, 8'h77, "R2 write above window");
        bus_write(12'h841, 8'h77, "R2 write high alias");
        bus_write(12'h001, 8'h77, "R2 write into read half");
        bus_read(12'h009, "R2 pointer untouched");
        bus_read(12'h049, "R2 read in write half ignored");
        bus_read(12'h809, "R2 read high alias ignored");
        bus_read(12'h009, "R2 pointer not stepped by ignored reads");
        bus_addr = 12'h009;
        @(negedge clk);
        check("R2 no strobe holds rdata", 32'(bus_rdata), 32'(m_rdata));
    endtask

    task automatic t_load();
        ld_en   = 1'b1;
        ld_addr = 11'h7FF - 11'h100;
        ld_data = 8'hC3;
        m_mem[11'h7FF - 11'h100] = 8'hC3;
        @(negedge clk);
        ld_en = 1'b0;
        set_ptr(0, 11'h100);
        bus_read(12'h008, "R11 loaded byte read back");
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        rng_value = 8'h00; tone_level = 8'h00; tone_hold = 3'b000;
        m_rdata = 8'h00;
        for (int c = 0; c < 8; c++) begin
            m_cnt[c] = '0; m_top[c] = '0; m_bot[c] = '0; m_flag[c] = '0;
        end
        // fill the display memory while reset is held
        for (int i = 0; i < 2048; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 11'(i);
            ld_data = 8'((i * 37 + (i >> 5)) ^ 8'h5A);
            m_mem[i] = 8'((i * 37 + (i >> 5)) ^ 8'h5A);
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_display();
        t_wrap();
        t_window();
        t_priority();
        t_side();
        t_hold();
        t_reseed();
        t_decode();
        t_load();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule